// File: doc/BRIEF.md
# Dual-Channel Converter Readout Sequencer

This block runs the host side of one conversion-and-readout cycle for a two-channel simultaneous-sampling converter. A one-cycle start request makes it drive the conversion-start line low for a programmable number of system clocks. It then follows the converter's busy line through a rise and a fall. Once the conversion is done, it drives chip select low and generates a serial clock from the system clock. It samples the data lines on each falling serial-clock edge and returns both result words together with a single-cycle valid strobe.

Two read styles are supported, and the mode input picks one of them at the moment of the start request. In dual-line mode both words arrive at the same time, one on each data line, over one frame of result-width clocks. In single-line mode chip select stays low for a further 14-clock frame, and the second channel's word follows the first on data line A. When the result is 12 bits wide, that second frame starts with two zero pad bits, and the block drops them. A parameter sets the result width to 12 or 14 bits.

Top module: `adc_dual_reader`

## Requirements
- R1: While rst_ni is low and after it is released, cnvst_no, cs_no and sclk_o are 1 and valid_o is 0.
- R2: A start_i sampled high in idle drives cnvst_no low for exactly CNV_LOW system clocks, beginning on the next clock edge.
- R3: cs_no falls only after busy_i has been seen high and then low following the conversion start; it falls on the edge after busy_i is sampled low.
- R4: sclk_o is 1 whenever cs_no is 1. The first falling edge of sclk_o comes exactly HALF_DIV system clocks after cs_no falls, so it never coincides with the fall of cs_no.
- R5: sclk_o holds each level for HALF_DIV system clocks. In dual-line mode (single_line_i = 0) exactly RES_BITS falling edges are issued per access.
- R6: Data are taken MSB first, one bit per falling sclk_o edge, from the value present on the line at that edge. In dual-line mode res_a_o is taken from dout_a_i and res_b_o from dout_b_i.
- R7: In single-line mode (single_line_i = 1) exactly RES_BITS+14 falling edges are issued. The bits taken at falls RES_BITS+1 to 14 (the pad bits, which exist only when RES_BITS = 12) are discarded. The last RES_BITS bits on dout_a_i form res_b_o, and the first RES_BITS bits form res_a_o.
- R8: valid_o is high for exactly one system clock, on the same edge where cs_no rises. res_a_o and res_b_o change only on that edge and hold their values until the next valid_o.
- R9: start_i is ignored while an access is in progress, so each access produces exactly one cnvst_no pulse. single_line_i is latched at the start request, and later changes to it do not affect that access.
- R10: With RES_BITS = 14, both read styles return 14-bit words, and single-line mode reads the second word with no pad bits (28 falls).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to start a conversion and readout |
| single_line_i | input | 1 | 1: both words read from dout_a_i; 0: one word per line |
| busy_i | input | 1 | Converter busy indication |
| dout_a_i | input | 1 | Serial data line of channel A |
| dout_b_i | input | 1 | Serial data line of channel B |
| cnvst_no | output | 1 | Conversion start, active low |
| cs_no | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Generated serial clock, idles high |
| res_a_o | output | RES_BITS | Channel A result |
| res_b_o | output | RES_BITS | Channel B result |
| valid_o | output | 1 | One-cycle strobe marking new results |

## Verification
A wrong fall counter or a wrong total-frame choice shows up at the ports within the same access. The count of sclk_o falls between the fall and the rise of cs_no is off, and the second word comes out shifted by the pad bits, so res_b_o differs from the word the converter model served. A wrong sequencer state shows up within a few clocks of start: cs_no falls before busy_i has finished, cnvst_no has the wrong width, or a second cnvst_no pulse appears during an access. Faults in the divider or the capture are visible in the first HALF_DIV gap and in the returned words. Sweeping many data patterns through both read styles at both widths exposes bit-order and bit-selection errors in one run.

// File: rtl/adc_rd_pkg.sv
`timescale 1ns/1ps
package adc_rd_pkg;
  localparam int SECOND_FRAME = 14;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CNV,
    ST_WAIT_HI,
    ST_WAIT_LO,
    ST_XFER
  } rd_state_e;
endpackage

// File: rtl/adc_rd_clkdiv.sv
`timescale 1ns/1ps
module adc_rd_clkdiv #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assert_tick_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(HALF_DIV - 1));
endmodule

// File: rtl/adc_rd_shifter.sv
`timescale 1ns/1ps
module adc_rd_shifter #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         din_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sr_q <= '0;
    else if (en_i) sr_q <= {sr_q[W-2:0], din_i};
  end

  assign word_o = sr_q;
endmodule

// File: rtl/adc_rd_seq.sv
`timescale 1ns/1ps
module adc_rd_seq
  import adc_rd_pkg::*;
#(
  parameter int RES_BITS = 12,
  parameter int CNV_LOW  = 3,
  localparam int IDX_W   = $clog2(RES_BITS + SECOND_FRAME + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             single_i,
  input  logic             busy_i,
  input  logic             tick_i,
  output logic             clk_en_o,
  output logic             cnvst_no,
  output logic             cs_no,
  output logic             sclk_o,
  output logic             sample_o,
  output logic [IDX_W-1:0] bit_idx_o,
  output logic             single_o,
  output logic             finish_o,
  output logic             done_o
);
  localparam int CW = (CNV_LOW > 1) ? $clog2(CNV_LOW) : 1;

  rd_state_e        state_q;
  logic [CW-1:0]    cnv_cnt_q;
  logic [IDX_W-1:0] bit_cnt_q;
  logic [IDX_W-1:0] total;
  logic             cnvst_n_q, cs_n_q, sclk_q, single_q, done_q;

  assign total     = single_q ? IDX_W'(RES_BITS + SECOND_FRAME) : IDX_W'(RES_BITS);
  assign clk_en_o  = (state_q == ST_XFER);
  assign sample_o  = clk_en_o && tick_i && sclk_q;
  assign finish_o  = clk_en_o && tick_i && !sclk_q && (bit_cnt_q == total);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnv_cnt_q <= '0;
      bit_cnt_q <= '0;
      cnvst_n_q <= 1'b1;
      cs_n_q    <= 1'b1;
      sclk_q    <= 1'b1;
      single_q  <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q   <= ST_CNV;
          cnvst_n_q <= 1'b0;
          cnv_cnt_q <= '0;
          single_q  <= single_i;
        end
        ST_CNV: begin
          if (cnv_cnt_q == CW'(CNV_LOW - 1)) begin
            cnvst_n_q <= 1'b1;
            state_q   <= ST_WAIT_HI;
          end else begin
            cnv_cnt_q <= cnv_cnt_q + 1'b1;
          end
        end
        ST_WAIT_HI: if (busy_i) state_q <= ST_WAIT_LO;
        ST_WAIT_LO: if (!busy_i) begin
          state_q   <= ST_XFER;
          cs_n_q    <= 1'b0;
          bit_cnt_q <= '0;
        end
        ST_XFER: if (tick_i) begin
          if (sclk_q) begin
            sclk_q    <= 1'b0;
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end else begin
            sclk_q <= 1'b1;
            if (bit_cnt_q == total) begin
              cs_n_q  <= 1'b1;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cnvst_no  = cnvst_n_q;
  assign cs_no     = cs_n_q;
  assign sclk_o    = sclk_q;
  assign bit_idx_o = bit_cnt_q;
  assign single_o  = single_q;
  assign done_o    = done_q;

  assert_clk_idle_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_q |-> sclk_q);
  assert_no_fall_with_cs_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_n_q) |-> sclk_q);
  assert_cs_after_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_n_q) |-> !$past(busy_i));
  assert_bit_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt_q <= total);
  assert_done_one_cycle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  assert_done_with_cs_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $rose(cs_n_q));
  assert_cnv_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_n_q |-> cnvst_n_q);
endmodule

// File: rtl/adc_dual_reader.sv
`timescale 1ns/1ps
module adc_dual_reader
  import adc_rd_pkg::*;
#(
  parameter int RES_BITS = 12,
  parameter int HALF_DIV = 2,
  parameter int CNV_LOW  = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                single_line_i,
  input  logic                busy_i,
  input  logic                dout_a_i,
  input  logic                dout_b_i,
  output logic                cnvst_no,
  output logic                cs_no,
  output logic                sclk_o,
  output logic [RES_BITS-1:0] res_a_o,
  output logic [RES_BITS-1:0] res_b_o,
  output logic                valid_o
);
  localparam int IDX_W   = $clog2(RES_BITS + SECOND_FRAME + 1);
  localparam int B_FIRST = SECOND_FRAME + (SECOND_FRAME - RES_BITS) + RES_BITS - SECOND_FRAME;

  logic             tick, clk_en, sample, single_q, finish, done;
  logic [IDX_W-1:0] bit_idx;
  logic             in_first, in_second, en_a, en_b, din_b;
  logic [RES_BITS-1:0] word_a, word_b;
  logic [RES_BITS-1:0] res_a_q, res_b_q;

  adc_rd_clkdiv #(.HALF_DIV(HALF_DIV)) u_clkdiv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (clk_en),
    .tick_o (tick)
  );

  adc_rd_seq #(.RES_BITS(RES_BITS), .CNV_LOW(CNV_LOW)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .single_i  (single_line_i),
    .busy_i    (busy_i),
    .tick_i    (tick),
    .clk_en_o  (clk_en),
    .cnvst_no  (cnvst_no),
    .cs_no     (cs_no),
    .sclk_o    (sclk_o),
    .sample_o  (sample),
    .bit_idx_o (bit_idx),
    .single_o  (single_q),
    .finish_o  (finish),
    .done_o    (done)
  );

  // second word starts after the pad bits, i.e. at index 14 for any width
  assign in_first  = bit_idx < IDX_W'(RES_BITS);
  assign in_second = bit_idx >= IDX_W'(B_FIRST);
  assign en_a      = sample && in_first;
  assign en_b      = sample && (single_q ? in_second : in_first);
  assign din_b     = single_q ? dout_a_i : dout_b_i;

  adc_rd_shifter #(.W(RES_BITS)) u_shift_a (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_a),
    .din_i  (dout_a_i),
    .word_o (word_a)
  );

  adc_rd_shifter #(.W(RES_BITS)) u_shift_b (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_b),
    .din_i  (din_b),
    .word_o (word_b)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_a_q <= '0;
      res_b_q <= '0;
    end else if (finish) begin
      res_a_q <= word_a;
      res_b_q <= word_b;
    end
  end

  assign res_a_o = res_a_q;
  assign res_b_o = res_b_q;
  assign valid_o = done;

  assert_res_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(res_a_o) && $stable(res_b_o)));
  assert_capture_in_frame_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_a || en_b) |-> !cs_no);
endmodule

// File: tb/adc_dual_reader_tb.sv
`timescale 1ns/1ps
module adc_conv_model #(
  parameter int RES = 12
) (
  input  logic        clk,
  input  logic        cnvst_n,
  input  logic        cs_n,
  input  logic        sclk,
  input  logic        valid,
  input  logic [13:0] word_a,
  input  logic [13:0] word_b,
  output logic        busy,
  output logic        dout_a,
  output logic        dout_b
);
  localparam int SW = RES + 14;

  logic [SW-1:0] sa, sb;
  int idx = 0;
  int low_cnt = 0, cnv_len = 0, cnv_count = 0, bt = -1;
  int gap_cnt = 0, gap = 0, fall_cnt = 0, falls = 0;
  int vcnt = 0, vwidth = 0, done_cnt = 0;
  int err_cs_early = 0, err_idle = 0, err_valid = 0;
  bit conv_done = 0, got_fall = 0;
  logic prev_cnv = 1, prev_cs = 1, prev_sclk = 1, prev_valid = 0;

  initial busy = 1'b0;

  assign sa     = {word_a[RES-1:0], 14'(word_b[RES-1:0])};
  assign sb     = {word_b[RES-1:0], 14'(word_a[RES-1:0])};
  assign dout_a = (idx < SW) ? sa[SW-1-idx] : 1'b0;
  assign dout_b = (idx < SW) ? sb[SW-1-idx] : 1'b0;

  always @(negedge clk) begin
    if (!cnvst_n) low_cnt++;
    if (!prev_cnv && cnvst_n) begin cnv_len = low_cnt; low_cnt = 0; end
    if (prev_cnv && !cnvst_n) begin cnv_count++; bt = 0; end
    if (bt >= 0) begin
      bt++;
      if (bt == 3) busy = 1'b1;
      if (bt == 13) begin busy = 1'b0; bt = -1; conv_done = 1; end
    end
    if (prev_cs && !cs_n) begin
      if (!conv_done) err_cs_early++;
      idx = 0; gap_cnt = 0; fall_cnt = 0; got_fall = 0;
    end
    if (!cs_n && !got_fall && sclk) gap_cnt++;
    if (!cs_n && prev_sclk && !sclk) begin
      fall_cnt++;
      idx++;
      if (!got_fall) begin gap = gap_cnt; got_fall = 1; end
    end
    if (!prev_cs && cs_n) begin falls = fall_cnt; conv_done = 0; end
    if (cs_n && !sclk) err_idle++;
    if (valid) begin
      vcnt++;
      if (!(cs_n && !prev_cs)) err_valid++;
    end
    if (prev_valid && !valid) begin vwidth = vcnt; vcnt = 0; done_cnt++; end
    prev_cnv = cnvst_n; prev_cs = cs_n; prev_sclk = sclk; prev_valid = valid;
  end
endmodule

module adc_dual_reader_tb;
  localparam int HALF = 2;
  localparam int CNVL = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic single = 1'b0;
  logic [13:0] wa12 = '0, wb12 = '0, wa14 = '0, wb14 = '0;

  logic busy12, da12, db12, cnv12, cs12, sclk12, v12;
  logic busy14, da14, db14, cnv14, cs14, sclk14, v14;
  logic [11:0] ra12, rb12;
  logic [13:0] ra14, rb14;

  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  adc_dual_reader #(.RES_BITS(12), .HALF_DIV(HALF), .CNV_LOW(CNVL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .single_line_i(single),
    .busy_i(busy12), .dout_a_i(da12), .dout_b_i(db12),
    .cnvst_no(cnv12), .cs_no(cs12), .sclk_o(sclk12),
    .res_a_o(ra12), .res_b_o(rb12), .valid_o(v12)
  );

  adc_dual_reader #(.RES_BITS(14), .HALF_DIV(HALF), .CNV_LOW(CNVL)) u_dut_w14 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .single_line_i(single),
    .busy_i(busy14), .dout_a_i(da14), .dout_b_i(db14),
    .cnvst_no(cnv14), .cs_no(cs14), .sclk_o(sclk14),
    .res_a_o(ra14), .res_b_o(rb14), .valid_o(v14)
  );

  adc_conv_model #(.RES(12)) m12 (
    .clk(clk), .cnvst_n(cnv12), .cs_n(cs12), .sclk(sclk12), .valid(v12),
    .word_a(wa12), .word_b(wb12), .busy(busy12), .dout_a(da12), .dout_b(db12)
  );

  adc_conv_model #(.RES(14)) m14 (
    .clk(clk), .cnvst_n(cnv14), .cs_n(cs14), .sclk(sclk14), .valid(v14),
    .word_a(wa14), .word_b(wb14), .busy(busy14), .dout_a(da14), .dout_b(db14)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic verify(input string w, input int res, input bit sgl,
                        input int ea, input int eb, input int ga, input int gb,
                        input int cl, input int gp, input int fl, input int vw,
                        input int cd, input int e_cs, input int e_idle, input int e_v);
    string rw;
    rw = (res == 14) ? " R10" : "";
    chk(cl == CNVL, {w, " R2 cnvst low width", rw}, cl, CNVL);
    chk(e_cs == 0, {w, " R3 cs before busy done", rw}, e_cs, 0);
    chk(gp == HALF, {w, " R4 first fall gap", rw}, gp, HALF);
    chk(e_idle == 0, {w, " R4 sclk low with cs high", rw}, e_idle, 0);
    if (sgl) chk(fl == res + 14, {w, " R7 single-line fall count", rw}, fl, res + 14);
    else     chk(fl == res, {w, " R5 dual-line fall count", rw}, fl, res);
    chk(ga == ea, {w, sgl ? " R7 word A" : " R6 word A", rw}, ga, ea);
    chk(gb == eb, {w, sgl ? " R7 word B after pad" : " R6 word B", rw}, gb, eb);
    chk(vw == 1, {w, " R8 valid width", rw}, vw, 1);
    chk(e_v == 0, {w, " R8 valid not on cs rise", rw}, e_v, 0);
    chk(cd == 1, {w, " R9 cnvst pulses per access", rw}, cd, 1);
  endtask

  task automatic run(input logic [13:0] a, input logic [13:0] b, input bit sgl, input bit disturb);
    int c12, c14, d12, d14, guard;
    int ha12, hb12, ha14, hb14;
    wa12 = {2'b00, a[11:0]}; wb12 = {2'b00, b[11:0]};
    wa14 = a; wb14 = b;
    c12 = m12.cnv_count; c14 = m14.cnv_count;
    d12 = m12.done_cnt;  d14 = m14.done_cnt;
    @(negedge clk); single = sgl; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (disturb) begin
      repeat (20) @(negedge clk);
      start = 1'b1; single = !sgl;
      @(negedge clk); start = 1'b0;
    end
    guard = 0;
    while (!(m12.done_cnt != d12 && m14.done_cnt != d14) && guard < 5000) begin
      @(negedge clk); guard++;
    end
    chk(guard < 5000, "R8 access completes", guard, 5000);
    single = sgl;
    verify("w12", 12, sgl, int'(a[11:0]), int'(b[11:0]), int'(ra12), int'(rb12),
           m12.cnv_len, m12.gap, m12.falls, m12.vwidth, m12.cnv_count - c12,
           m12.err_cs_early, m12.err_idle, m12.err_valid);
    verify("w14", 14, sgl, int'(a), int'(b), int'(ra14), int'(rb14),
           m14.cnv_len, m14.gap, m14.falls, m14.vwidth, m14.cnv_count - c14,
           m14.err_cs_early, m14.err_idle, m14.err_valid);
    ha12 = int'(ra12); hb12 = int'(rb12); ha14 = int'(ra14); hb14 = int'(rb14);
    repeat (8) @(negedge clk);
    chk(int'(ra12) == ha12 && int'(rb12) == hb12, "w12 R8 results held", int'(ra12), ha12);
    chk(int'(ra14) == ha14 && int'(rb14) == hb14, "w14 R8 results held", int'(ra14), ha14);
    chk(!v12 && !v14, "R8 valid low when idle", int'(v12) + int'(v14), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cnv12 && cs12 && sclk12 && !v12, "w12 R1 outputs in reset", {cnv12, cs12, sclk12, v12}, 4'b1110);
    chk(cnv14 && cs14 && sclk14 && !v14, "w14 R1 outputs in reset", {cnv14, cs14, sclk14, v14}, 4'b1110);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cnv12 && cs12 && sclk12 && !v12, "w12 R1 idle after reset", {cnv12, cs12, sclk12, v12}, 4'b1110);
    chk(cnv14 && cs14 && sclk14 && !v14, "w14 R1 idle after reset", {cnv14, cs14, sclk14, v14}, 4'b1110);
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < 16; i++) begin
        logic [13:0] a, b;
        a = 14'(i * 14'h1357 + 14'h02A5);
        b = ~a ^ 14'(i << 3);
        if (i == 0) begin a = '0; b = '1; end
        if (i == 1) begin a = '1; b = '0; end
        run(a, b, s[0], (i % 5) == 2);
      end
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule